// File: doc/BRIEF.md
# Dataway Command Decoder with Conditional Acceptance

This block sits behind the dataway slave port of a parallel-link interface module. Each command strobe carries a 5-bit function code, a subaddress and a 24-bit write word. The block decodes the small set of functions the module supports at subaddress 0. It answers each one with an X (command recognised) and a Q (command accepted). Q is fixed for housekeeping functions. For data-path functions it is computed from the transfer status flags that the rest of the module supplies.

The block holds the 8-bit control register. Its low nibble is free static outputs, bit 5 is the enable line, bit 6 is the on line and bit 7 selects block-transfer reads. It also holds the "header expected" flag, which must be cleared by an accepted header load before any FIFO or header-continuation write can be accepted. It returns read data: the output-register word, a status word, or the fixed module identifier. It raises one-cycle write strobes toward the outbound FIFO and the header path, but only when the command was accepted.

By default every response is registered. The response for a command appears one clock after its strobe, together with `resp_valid`.

Top module: `camac_cmd_decoder`

## Requirements
- R1: Functions 0, 1, 4, 6, 9, 16, 17, 20, 22, 24, 26, 28 and 30 at subaddress 0 are recognised. One cycle after `cmd_stb`, `resp_valid` is 1 and `x_resp` is 1. Q is never given without X.
- R2: Any other function code, or any nonzero subaddress, gives `resp_valid` with X=0, Q=0, read data 0 and no strobe. It leaves the control register and the header-expected flag unchanged.
- R3: Function 6 returns read data 0x000050 with Q=1.
- R4: Function 9 and the `mod_clr` input both clear control bit 7 and set the header-expected flag. Function 9 answers Q=1. Reset also leaves the flag set.
- R5: Function 0 gets Q iff `out_ready`=1, bit 7=0 and `xfer_to`=0. Function 4 gets Q iff `out_ready`=1, bit 7=1 and `xfer_to`=0. Either one returns `or_data` when Q=1 and 0 when Q=0.
- R6: Function 16 gets Q iff `xfer_to`, `out_ready`, `out_seq`, bit 7 and the header-expected flag are all 0 and `fifo_in_rdy`=1.
- R7: Function 22 gets Q under the function-16 condition with bit 7 ignored.
- R8: Function 20 gets Q iff `xfer_pend`, `xfer_to` and `out_ready` are all 0. When accepted, it loads bit 7 from write-data bit index 23 and clears the header-expected flag.
- R9: Function 17 loads control bits 3:0 from write bits 3:0. Functions 24 and 26 clear and set bit 5, and functions 28 and 30 clear and set bit 6. All five answer Q=1 and touch no other bit.
- R10: Function 1 answers Q=1 and returns a status word laid out as follows. Bits 7:0 hold the control register and bits 15:8 hold `ext_status`. Bits 16 through 21 hold, in that order, the header-expected flag, `fifo_in_rdy`, `xfer_pend`, `xfer_to`, `out_seq` and `out_ready`. Bits 23:22 are 0.
- R11: `fifo_wr_stb` (function 16), `hdr_load_stb` (function 20) and `hdr_more_stb` (function 22) pulse for one cycle in the response cycle, only when Q=1. At most one of them is high at a time, and `stb_data` then carries that command's write word.
- R12: After reset the control register is 0, the header-expected flag is 1, and `resp_valid` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command present this cycle |
| func | input | 5 | Function code |
| subaddr | input | 4 | Subaddress |
| wdata | input | 24 | Write word |
| mod_clr | input | 1 | Module clear |
| out_ready | input | 1 | Output register holds data |
| out_seq | input | 1 | Output sequence in progress |
| xfer_to | input | 1 | Transfer time-out |
| xfer_pend | input | 1 | Transfer pending |
| fifo_in_rdy | input | 1 | Outbound FIFO can take a word |
| ext_status | input | 8 | External static status lines |
| or_data | input | 24 | Output register contents |
| resp_valid | output | 1 | Response for last command is present |
| x_resp | output | 1 | Command recognised |
| q_resp | output | 1 | Command accepted |
| rdata | output | 24 | Read data |
| ctrl_reg | output | 8 | Control register |
| expect_hdr | output | 1 | Header-expected flag |
| fifo_wr_stb | output | 1 | FIFO write strobe |
| hdr_load_stb | output | 1 | Header load strobe |
| hdr_more_stb | output | 1 | Header continuation strobe |
| stb_data | output | 24 | Write word of the responded command |

## Verification
The assertions assume that `mod_clr` and `cmd_stb` are never high in the same cycle. They also assume that the status flags stay steady for the whole cycle in which a command is sampled. The stimulus changes flags only between commands and pulses the clear on its own. It leaves at least one idle cycle after every command, so each response can be tied to a single expected entry.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

   localparam int FUNC_W = 5;

   typedef enum logic [FUNC_W-1:0] {
      FN_RD_OUT  = 5'd0,
      FN_RD_STAT = 5'd1,
      FN_RD_BLK  = 5'd4,
      FN_RD_ID   = 5'd6,
      FN_CLEAR   = 5'd9,
      FN_WR_FIFO = 5'd16,
      FN_WR_CTRL = 5'd17,
      FN_WR_HDR  = 5'd20,
      FN_WR_MORE = 5'd22,
      FN_ENA_OFF = 5'd24,
      FN_ENA_ON  = 5'd26,
      FN_RUN_OFF = 5'd28,
      FN_RUN_ON  = 5'd30
   } func_e;

   // one-hot decode of a recognised command
   typedef struct packed {
      logic rd_out;
      logic rd_stat;
      logic rd_blk;
      logic rd_id;
      logic clear;
      logic wr_fifo;
      logic wr_ctrl;
      logic wr_hdr;
      logic wr_more;
      logic ena_off;
      logic ena_on;
      logic run_off;
      logic run_on;
   } dec_t;

   typedef struct packed {
      logic out_ready;
      logic out_seq;
      logic xfer_to;
      logic xfer_pend;
      logic fifo_in_rdy;
   } flags_t;

endpackage

// File: rtl/cmdq_func_decode.sv
module cmdq_func_decode
   import cmdq_pkg::*;
#(
   parameter int SA_W = 4
) (
   input  logic              cmd_stb,
   input  logic [FUNC_W-1:0] func,
   input  logic [SA_W-1:0]   subaddr,
   output dec_t              dec,
   output logic              known
);

   always_comb begin
      dec = '0;
      if (cmd_stb && (subaddr == '0)) begin
         case (func)
            FN_RD_OUT:  dec.rd_out  = 1'b1;
            FN_RD_STAT: dec.rd_stat = 1'b1;
            FN_RD_BLK:  dec.rd_blk  = 1'b1;
            FN_RD_ID:   dec.rd_id   = 1'b1;
            FN_CLEAR:   dec.clear   = 1'b1;
            FN_WR_FIFO: dec.wr_fifo = 1'b1;
            FN_WR_CTRL: dec.wr_ctrl = 1'b1;
            FN_WR_HDR:  dec.wr_hdr  = 1'b1;
            FN_WR_MORE: dec.wr_more = 1'b1;
            FN_ENA_OFF: dec.ena_off = 1'b1;
            FN_ENA_ON:  dec.ena_on  = 1'b1;
            FN_RUN_OFF: dec.run_off = 1'b1;
            FN_RUN_ON:  dec.run_on  = 1'b1;
            default:    dec = '0;
         endcase
      end
   end

   assign known = |dec;

endmodule

// File: rtl/cmdq_qualify.sv
module cmdq_qualify
   import cmdq_pkg::*;
(
   input  dec_t   dec,
   input  flags_t fl,
   input  logic   blk_mode,
   input  logic   expect_hdr,
   output logic   q
);

   logic always_q;
   logic wr_ok;
   logic rd_ok;

   assign always_q = dec.rd_stat | dec.rd_id | dec.clear | dec.wr_ctrl |
                     dec.ena_off | dec.ena_on | dec.run_off | dec.run_on;

   // common gate of the outbound data writes
   assign wr_ok = !fl.xfer_to && !fl.out_ready && !fl.out_seq &&
                  fl.fifo_in_rdy && !expect_hdr;

   assign rd_ok = fl.out_ready && !fl.xfer_to;

   always_comb begin
      q = always_q;
      if (dec.rd_out && rd_ok && !blk_mode)  q = 1'b1;
      if (dec.rd_blk && rd_ok && blk_mode)   q = 1'b1;
      if (dec.wr_fifo && wr_ok && !blk_mode) q = 1'b1;
      if (dec.wr_more && wr_ok)              q = 1'b1;
      if (dec.wr_hdr && !fl.xfer_pend && !fl.xfer_to && !fl.out_ready) q = 1'b1;
   end

endmodule

// File: rtl/cmdq_ctrl_regs.sv
module cmdq_ctrl_regs
   import cmdq_pkg::*;
#(
   parameter int CTRL_W  = 8,
   parameter int LOW_W   = 4,
   parameter int ENA_BIT = 5,
   parameter int RUN_BIT = 6,
   parameter int BLK_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dec_t              dec,
   input  logic              q,
   input  logic [LOW_W-1:0]  low_data,
   input  logic              hdr_blk,
   input  logic              mod_clr,
   output logic [CTRL_W-1:0] ctrl,
   output logic              expect_hdr
);

   logic clr_req;
   assign clr_req = mod_clr | dec.clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl       <= '0;
         expect_hdr <= 1'b1;
      end else begin
         if (dec.wr_ctrl) ctrl[LOW_W-1:0] <= low_data;
         if (dec.ena_off) ctrl[ENA_BIT]   <= 1'b0;
         if (dec.ena_on)  ctrl[ENA_BIT]   <= 1'b1;
         if (dec.run_off) ctrl[RUN_BIT]   <= 1'b0;
         if (dec.run_on)  ctrl[RUN_BIT]   <= 1'b1;
         if (dec.wr_hdr && q) begin
            ctrl[BLK_BIT] <= hdr_blk;
            expect_hdr    <= 1'b0;
         end
         if (clr_req) begin
            ctrl[BLK_BIT] <= 1'b0;
            expect_hdr    <= 1'b1;
         end
      end
   end

   AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (!ctrl[BLK_BIT] && expect_hdr)); // R4
   AST_ENA_SET: assert property (@(posedge clk) disable iff (!rst_n)
      dec.ena_on |=> ctrl[ENA_BIT]); // R9
   AST_RUN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      dec.run_off |=> !ctrl[RUN_BIT]); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dec == '0 && !mod_clr) |=> ($stable(ctrl) && $stable(expect_hdr))); // R2

endmodule

// File: rtl/camac_cmd_decoder.sv
module camac_cmd_decoder
   import cmdq_pkg::*;
#(
   parameter int          DATA_W   = 24,
   parameter int          SA_W     = 4,
   parameter int          STAT_W   = 8,
   parameter int          CTRL_W   = 8,
   parameter int          LOW_W    = 4,
   parameter int          HDR_BIT  = 23,
   parameter logic [7:0]  MOD_ID   = 8'h50,
   parameter bit          RESP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_stb,
   input  logic [FUNC_W-1:0] func,
   input  logic [SA_W-1:0]   subaddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mod_clr,
   input  logic              out_ready,
   input  logic              out_seq,
   input  logic              xfer_to,
   input  logic              xfer_pend,
   input  logic              fifo_in_rdy,
   input  logic [STAT_W-1:0] ext_status,
   input  logic [DATA_W-1:0] or_data,
   output logic              resp_valid,
   output logic              x_resp,
   output logic              q_resp,
   output logic [DATA_W-1:0] rdata,
   output logic [CTRL_W-1:0] ctrl_reg,
   output logic              expect_hdr,
   output logic              fifo_wr_stb,
   output logic              hdr_load_stb,
   output logic              hdr_more_stb,
   output logic [DATA_W-1:0] stb_data
);

   localparam int FLAG_N   = 6;
   localparam int FLAG_LSB = CTRL_W + STAT_W;
   localparam int ID_W     = 8;
   localparam int BLK_BIT  = 7;

   // elaboration checks
   if (CTRL_W < 8) begin : g_bad_ctrl
      $fatal(1, "CTRL_W must hold bits 7:0");
   end
   if (LOW_W < 1 || LOW_W > 5) begin : g_bad_low
      $fatal(1, "LOW_W must leave bits 5 to 7 free");
   end
   if (FLAG_LSB + FLAG_N > DATA_W) begin : g_bad_stat
      $fatal(1, "status word does not fit DATA_W");
   end
   if (HDR_BIT >= DATA_W || DATA_W < ID_W) begin : g_bad_data
      $fatal(1, "HDR_BIT or DATA_W out of range");
   end

   dec_t   dec;
   logic   known;
   logic   q_c;
   flags_t fl;
   logic   exp_q;
   logic [CTRL_W-1:0] ctrl_q;

   assign fl = {out_ready, out_seq, xfer_to, xfer_pend, fifo_in_rdy};

   cmdq_func_decode #(.SA_W(SA_W)) u_dec (
      .cmd_stb (cmd_stb),
      .func    (func),
      .subaddr (subaddr),
      .dec     (dec),
      .known   (known)
   );

   cmdq_qualify u_qual (
      .dec        (dec),
      .fl         (fl),
      .blk_mode   (ctrl_q[BLK_BIT]),
      .expect_hdr (exp_q),
      .q          (q_c)
   );

   cmdq_ctrl_regs #(
      .CTRL_W  (CTRL_W),
      .LOW_W   (LOW_W),
      .ENA_BIT (5),
      .RUN_BIT (6),
      .BLK_BIT (BLK_BIT)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec        (dec),
      .q          (q_c),
      .low_data   (wdata[LOW_W-1:0]),
      .hdr_blk    (wdata[HDR_BIT]),
      .mod_clr    (mod_clr),
      .ctrl       (ctrl_q),
      .expect_hdr (exp_q)
   );

   assign ctrl_reg   = ctrl_q;
   assign expect_hdr = exp_q;

   // read data selection
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] rdata_c;
   logic [2:0]        stb_c;

   always_comb begin
      stat_word = '0;
      stat_word[CTRL_W-1:0]         = ctrl_q;
      stat_word[CTRL_W +: STAT_W]   = ext_status;
      stat_word[FLAG_LSB +: FLAG_N] = {fl, exp_q};
   end

   always_comb begin
      rdata_c = '0;
      if (dec.rd_id)                             rdata_c[ID_W-1:0] = MOD_ID;
      else if (dec.rd_stat)                      rdata_c = stat_word;
      else if ((dec.rd_out || dec.rd_blk) && q_c) rdata_c = or_data;
   end

   assign stb_c = {dec.wr_fifo & q_c, dec.wr_hdr & q_c, dec.wr_more & q_c};

   if (RESP_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            resp_valid   <= 1'b0;
            x_resp       <= 1'b0;
            q_resp       <= 1'b0;
            rdata        <= '0;
            fifo_wr_stb  <= 1'b0;
            hdr_load_stb <= 1'b0;
            hdr_more_stb <= 1'b0;
            stb_data     <= '0;
         end else begin
            resp_valid   <= cmd_stb;
            x_resp       <= known;
            q_resp       <= q_c;
            rdata        <= rdata_c;
            fifo_wr_stb  <= stb_c[2];
            hdr_load_stb <= stb_c[1];
            hdr_more_stb <= stb_c[0];
            stb_data     <= wdata;
         end
      end

      AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         resp_valid |-> $past(cmd_stb)); // R1
   end else begin : g_comb
      assign resp_valid   = cmd_stb;
      assign x_resp       = known;
      assign q_resp       = q_c;
      assign rdata        = rdata_c;
      assign fifo_wr_stb  = stb_c[2];
      assign hdr_load_stb = stb_c[1];
      assign hdr_more_stb = stb_c[0];
      assign stb_data     = wdata;
   end

   AST_Q_NEEDS_X: assert property (@(posedge clk) disable iff (!rst_n)
      q_resp |-> x_resp); // R1
   AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fifo_wr_stb, hdr_load_stb, hdr_more_stb})); // R11
   AST_STB_NEEDS_Q: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr_stb || hdr_load_stb || hdr_more_stb) |-> (q_resp && resp_valid)); // R11
   AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !x_resp) |-> (rdata == '0)); // R2

endmodule

// File: tb/camac_cmd_decoder_tb.sv
module camac_cmd_decoder_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_stb = 1'b0;
   logic [4:0]  func = '0;
   logic [3:0]  subaddr = '0;
   logic [23:0] wdata = '0;
   logic        mod_clr = 1'b0;
   logic        out_ready = 1'b0, out_seq = 1'b0, xfer_to = 1'b0;
   logic        xfer_pend = 1'b0, fifo_in_rdy = 1'b0;
   logic [7:0]  ext_status = '0;
   logic [23:0] or_data = 24'h3C5A96;
   logic        resp_valid, x_resp, q_resp, expect_hdr;
   logic [23:0] rdata, stb_data;
   logic [7:0]  ctrl_reg;
   logic        fifo_wr_stb, hdr_load_stb, hdr_more_stb;

   always #(CLK_PERIOD/2) clk = ~clk;

   camac_cmd_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .func(func),
      .subaddr(subaddr), .wdata(wdata), .mod_clr(mod_clr),
      .out_ready(out_ready), .out_seq(out_seq), .xfer_to(xfer_to),
      .xfer_pend(xfer_pend), .fifo_in_rdy(fifo_in_rdy),
      .ext_status(ext_status), .or_data(or_data),
      .resp_valid(resp_valid), .x_resp(x_resp), .q_resp(q_resp),
      .rdata(rdata), .ctrl_reg(ctrl_reg), .expect_hdr(expect_hdr),
      .fifo_wr_stb(fifo_wr_stb), .hdr_load_stb(hdr_load_stb),
      .hdr_more_stb(hdr_more_stb), .stb_data(stb_data)
   );

   typedef struct packed {
      logic        x;
      logic        q;
      logic [23:0] rd;
      logic [7:0]  ctrl;
      logic        exph;
      logic [2:0]  stb;
      logic [23:0] sd;
   } item_t;

   item_t exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    failures = 0;

   // reference state
   logic [7:0] m_ctrl = 8'h00;
   logic       m_exp  = 1'b1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic set_flags(input logic ordy, input logic seq, input logic to,
                            input logic pend, input logic fir);
      @(negedge clk);
      out_ready = ordy; out_seq = seq; xfer_to = to;
      xfer_pend = pend; fifo_in_rdy = fir;
   endtask

   // driver: issues one command and pushes the expected response
   task automatic send(input logic [4:0] f, input logic [3:0] sa,
                       input logic [23:0] wd, input string tag);
      item_t it;
      bit    known;
      bit    q;
      bit    wr_ok;
      @(negedge clk);
      func = f; subaddr = sa; wdata = wd; cmd_stb = 1'b1;
      known = (sa == 4'd0) && (f inside {5'd0, 5'd1, 5'd4, 5'd6, 5'd9, 5'd16,
               5'd17, 5'd20, 5'd22, 5'd24, 5'd26, 5'd28, 5'd30});
      wr_ok = !xfer_to && !out_ready && !out_seq && fifo_in_rdy && !m_exp;
      q = 1'b0;
      it = '0;
      if (known) begin
         case (f)
            5'd0:  q = out_ready && !m_ctrl[7] && !xfer_to;
            5'd4:  q = out_ready && m_ctrl[7] && !xfer_to;
            5'd16: q = wr_ok && !m_ctrl[7];
            5'd22: q = wr_ok;
            5'd20: q = !xfer_pend && !xfer_to && !out_ready;
            default: q = 1'b1;
         endcase
         if (f == 5'd6) it.rd = 24'h000050;
         if (f == 5'd1) it.rd = {2'b00, out_ready, out_seq, xfer_to, xfer_pend,
                                 fifo_in_rdy, m_exp, ext_status, m_ctrl};
         if ((f == 5'd0 || f == 5'd4) && q) it.rd = or_data;
         it.stb = {f == 5'd16 && q, f == 5'd20 && q, f == 5'd22 && q};
         // state update
         case (f)
            5'd17: m_ctrl[3:0] = wd[3:0];
            5'd24: m_ctrl[5] = 1'b0;
            5'd26: m_ctrl[5] = 1'b1;
            5'd28: m_ctrl[6] = 1'b0;
            5'd30: m_ctrl[6] = 1'b1;
            5'd9:  begin m_ctrl[7] = 1'b0; m_exp = 1'b1; end
            5'd20: if (q) begin m_ctrl[7] = wd[23]; m_exp = 1'b0; end
            default: ;
         endcase
      end
      it.x = known;
      it.q = q;
      it.ctrl = m_ctrl;
      it.exph = m_exp;
      it.sd = wd;
      exp_q.push_back(it);
      tag_q.push_back(tag);
      @(negedge clk);
      cmd_stb = 1'b0;
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      mod_clr = 1'b1;
      m_ctrl[7] = 1'b0;
      m_exp = 1'b1;
      @(negedge clk);
      mod_clr = 1'b0;
      chk(ctrl_reg[7] == 1'b0, "R4", "clear bit7", 32'(ctrl_reg[7]), 32'd0);
      chk(expect_hdr == 1'b1, "R4", "clear flag", 32'(expect_hdr), 32'd1);
   endtask

   // monitor: compares each response against the scoreboard
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected response", 32'd1, 32'd0);
         end else begin
            item_t e;
            string t;
            bit    any_stb;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            any_stb = fifo_wr_stb | hdr_load_stb | hdr_more_stb;
            chk(x_resp == e.x, t, "x", 32'(x_resp), 32'(e.x));
            chk(q_resp == e.q, t, "q", 32'(q_resp), 32'(e.q));
            chk(rdata == e.rd, t, "rdata", 32'(rdata), 32'(e.rd));
            chk(ctrl_reg == e.ctrl, t, "ctrl", 32'(ctrl_reg), 32'(e.ctrl));
            chk(expect_hdr == e.exph, t, "hdr flag", 32'(expect_hdr), 32'(e.exph));
            chk({fifo_wr_stb, hdr_load_stb, hdr_more_stb} == e.stb, t, "strobes",
                32'({fifo_wr_stb, hdr_load_stb, hdr_more_stb}), 32'(e.stb));
            if (any_stb)
               chk(stb_data == e.sd, "R11", "stb_data", 32'(stb_data), 32'(e.sd));
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(ctrl_reg == 8'h00, "R12", "reset ctrl", 32'(ctrl_reg), 32'd0);
      chk(expect_hdr == 1'b1, "R12", "reset flag", 32'(expect_hdr), 32'd1);
      chk(resp_valid == 1'b0, "R12", "reset valid", 32'(resp_valid), 32'd0);
      chk({fifo_wr_stb, hdr_load_stb, hdr_more_stb} == 3'b000, "R12",
          "reset strobes", 32'({fifo_wr_stb, hdr_load_stb, hdr_more_stb}), 32'd0);

      send(5'd6, 4'd0, 24'h123456, "R3");
      ext_status = 8'hA5;
      set_flags(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      send(5'd1, 4'd0, 24'h0, "R10");
      set_flags(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      send(5'd17, 4'd0, 24'hFFFFFA, "R9");
      send(5'd26, 4'd0, 24'h0, "R9");
      send(5'd30, 4'd0, 24'h0, "R9");
      send(5'd24, 4'd0, 24'h0, "R9");
      send(5'd1, 4'd0, 24'h0, "R10");
      send(5'd28, 4'd0, 24'h0, "R9");
      send(5'd26, 4'd0, 24'h0, "R9");

      // header flag still set: writes refused
      send(5'd16, 4'd0, 24'h111111, "R6");
      send(5'd22, 4'd0, 24'h222222, "R7");
      set_flags(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      send(5'd20, 4'd0, 24'h800000, "R8");
      set_flags(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      send(5'd20, 4'd0, 24'h800001, "R8");

      // block mode on
      send(5'd22, 4'd0, 24'h333333, "R7");
      send(5'd16, 4'd0, 24'h444444, "R6");
      set_flags(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      send(5'd4, 4'd0, 24'h0, "R5");
      send(5'd0, 4'd0, 24'h0, "R5");
      send(5'd20, 4'd0, 24'h000000, "R8");
      set_flags(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      send(5'd20, 4'd0, 24'h7FFFFF, "R8");

      // block mode off
      send(5'd16, 4'd0, 24'h555555, "R6");
      set_flags(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      send(5'd16, 4'd0, 24'h666666, "R6");
      set_flags(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      send(5'd16, 4'd0, 24'h777777, "R6");
      set_flags(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      send(5'd22, 4'd0, 24'h888888, "R7");
      set_flags(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      or_data = 24'hC0FFEE;
      send(5'd0, 4'd0, 24'h0, "R5");
      send(5'd4, 4'd0, 24'h0, "R5");
      set_flags(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      send(5'd0, 4'd0, 24'h0, "R5");

      // unrecognised codes and subaddresses
      set_flags(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      send(5'd2, 4'd0, 24'hFFFFFF, "R2");
      send(5'd24, 4'd3, 24'h0, "R2");
      send(5'd17, 4'd1, 24'h000005, "R2");
      send(5'd20, 4'd2, 24'h800000, "R2");
      send(5'd1, 4'd0, 24'h0, "R2");

      // clears
      send(5'd20, 4'd0, 24'h800000, "R8");
      send(5'd9, 4'd0, 24'h0, "R4");
      send(5'd20, 4'd0, 24'hFFFFFF, "R8");
      pulse_clear();
      send(5'd1, 4'd0, 24'h0, "R4");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R1", "responses outstanding",
          32'(exp_q.size()), 32'd0);
      finish_run();
   end

endmodule